// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits between the byte-load controller of an emulated flash memory and its sector write buffer and program timer. For every decoded byte load (address and data) it decides whether the byte is an ordinary data byte, which goes on to the write buffer, or one step of a command sequence, which is consumed. When a load window closes, it starts the program timer. It also says whether that program cycle may change the array, or must run as a rejected cycle that keeps the timer busy but leaves the data unchanged.

A persistent protection flag decides the outcome. The flag is off at power-on. While it is off, every window commits. A three-write prefix sets the flag, and that prefix also unlocks the window it starts. While the flag is on, a window commits only if it opens with that prefix. A six-write sequence clears the flag. All command addresses and data values are parameters. The flag has its own power-on initialization input and keeps its value through the ordinary reset.

Top module: `sdp_guard`

## Requirements
- R1: A byte load that is not consumed as a command step sets `buf_we` high for exactly one cycle, in the cycle after the load. `buf_addr` and `buf_data` carry the loaded address and data in that cycle.
- R2: A byte load that matches the expected command step does not raise `buf_we`. The steps are: first 5555h/AAh, second 2AAAh/55h, then either 5555h/A0h (enable), or 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/20h (disable).
- R3: Completing the three-step enable prefix (5555h/AAh, 2AAAh/55h, 5555h/A0h) makes `prot_on` read 1 in the cycle after the third load. Later bytes in the same window are data.
- R4: Completing the six-step disable sequence (5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/20h) makes `prot_on` read 0 in the cycle after the sixth load.
- R5: A byte whose address or data does not match the expected step is treated as data. Bytes of the same partial sequence that were already consumed stay consumed.
- R6: Commands are recognized only at the head of a window. After the first data byte, no byte in that window is consumed until `win_close`.
- R7: A `win_close` pulse in a window that had at least one load gives a one-cycle `prog_start` pulse in the next cycle. A `win_close` with no load in the window gives no pulse.
- R8: `prog_commit` pulses together with `prog_start` when `prot_on` is 0, or when the window carried a complete enable or disable sequence. Otherwise `prog_start` pulses alone, which is a rejected cycle.
- R9: `rst_n` low clears the matcher, the window state and all pulse outputs, but leaves `prot_on` unchanged.
- R10: `por_n` low clears `prot_on` to 0. This is the initial state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for matcher and window state |
| por_n | input | 1 | Asynchronous active-low power-on initialization of the protection flag |
| ld_valid | input | 1 | One-cycle strobe for a decoded byte load |
| ld_addr | input | ADDR_W | Address of the byte load |
| ld_data | input | DATA_W | Data of the byte load |
| win_close | input | 1 | One-cycle strobe that the load window has ended |
| buf_we | output | 1 | Write strobe toward the sector write buffer |
| buf_addr | output | ADDR_W | Address for the write buffer |
| buf_data | output | DATA_W | Data for the write buffer |
| prog_start | output | 1 | Start pulse for the program timer |
| prog_commit | output | 1 | Permission for this program cycle to change the array |
| prot_on | output | 1 | Current state of the protection flag |

## Verification
The assertions assume that `ld_valid` and `win_close` are never high in the same cycle. They also assume that both strobes are single-cycle events coming from the upstream load controller, and one property checks the first of these assumptions at the inputs. The stimulus drives each load or close for one cycle and leaves at least one idle cycle before the next event. It never drives a load during either reset, so flag changes can always be traced back to the load in the previous cycle.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  // Matcher phase inside one load window
  typedef enum logic {
    MP_HUNT = 1'b0,   // still at the head of the window, commands may match
    MP_LOCK = 1'b1    // a data byte or a finished sequence was seen
  } mphase_t;

  localparam int unsigned SEQ_STEPS = 6;   // longest command sequence
  localparam int unsigned EN_STEP   = 2;   // index at which the enable path ends

endpackage

// File: rtl/sdp_seq_match.sv
module sdp_seq_match
  import sdp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] A_ADDR    = 16'h5555,
  parameter logic [ADDR_W-1:0] B_ADDR    = 16'h2AAA,
  parameter logic [DATA_W-1:0] D_FIRST   = 8'hAA,
  parameter logic [DATA_W-1:0] D_SECOND  = 8'h55,
  parameter logic [DATA_W-1:0] D_ENABLE  = 8'hA0,
  parameter logic [DATA_W-1:0] D_DIS_MID = 8'h80,
  parameter logic [DATA_W-1:0] D_DISABLE = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              win_close,
  output logic              cmd_byte,
  output logic              en_done,
  output logic              dis_done
);

  localparam int unsigned SW = $clog2(SEQ_STEPS);
  localparam logic [SW-1:0] STEP_EN   = SW'(EN_STEP);
  localparam logic [SW-1:0] STEP_LAST = SW'(SEQ_STEPS - 1);

  // Disable sequence, step 0 in the lowest slot; the enable path shares steps 0 and 1
  localparam logic [SEQ_STEPS-1:0][ADDR_W-1:0] SEQ_A =
    {A_ADDR, B_ADDR, A_ADDR, A_ADDR, B_ADDR, A_ADDR};
  localparam logic [SEQ_STEPS-1:0][DATA_W-1:0] SEQ_D =
    {D_DISABLE, D_SECOND, D_FIRST, D_DIS_MID, D_SECOND, D_FIRST};

  logic [SEQ_STEPS-1:0] step_hit;
  logic                 en_hit;

  genvar gi;
  generate
    for (gi = 0; gi < SEQ_STEPS; gi++) begin : g_step
      assign step_hit[gi] = (ld_addr == SEQ_A[gi]) && (ld_data == SEQ_D[gi]);
    end
  endgenerate

  assign en_hit = (ld_addr == A_ADDR) && (ld_data == D_ENABLE);

  mphase_t         phase_q, phase_d;
  logic [SW-1:0]   step_q,  step_d;
  logic            state_en;

  // Next-state logic
  always_comb begin
    phase_d  = phase_q;
    step_d   = step_q;
    cmd_byte = 1'b0;
    en_done  = 1'b0;
    dis_done = 1'b0;
    if (win_close) begin
      phase_d = MP_HUNT;
      step_d  = '0;
    end else if (ld_valid && (phase_q == MP_HUNT)) begin
      if ((step_q == STEP_EN) && en_hit) begin
        cmd_byte = 1'b1;
        en_done  = 1'b1;
        phase_d  = MP_LOCK;
        step_d   = '0;
      end else if (step_hit[step_q]) begin
        cmd_byte = 1'b1;
        if (step_q == STEP_LAST) begin
          dis_done = 1'b1;
          phase_d  = MP_LOCK;
          step_d   = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end else begin
        // mismatch: this byte is data, stop hunting for the rest of the window
        phase_d = MP_LOCK;
        step_d  = '0;
      end
    end
  end

  assign state_en = win_close | ld_valid;

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= MP_HUNT;
      step_q  <= '0;
    end else if (state_en) begin
      phase_q <= phase_d;
      step_q  <= step_d;
    end
  end

endmodule

// File: rtl/sdp_prot_flag.sv
module sdp_prot_flag (
  input  logic clk,
  input  logic por_n,
  input  logic set_i,
  input  logic clr_i,
  output logic prot_o
);

  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i & ~clr_i;
  end

  // Only the power-on initialization clears this register
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign prot_o = flag_q;

endmodule

// File: rtl/sdp_window.sv
module sdp_window #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              win_close,
  input  logic              cmd_byte,
  input  logic              unlock,
  input  logic              prot_on,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_data,
  output logic              prog_start,
  output logic              prog_commit
);

  logic              any_q,    any_d;
  logic              unlk_q,   unlk_d;
  logic              we_q,     we_d;
  logic              start_q,  start_d;
  logic              commit_q, commit_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              win_en, fwd_en;

  // Next-state logic
  always_comb begin
    any_d    = any_q;
    unlk_d   = unlk_q;
    start_d  = 1'b0;
    commit_d = 1'b0;
    we_d     = ld_valid & ~cmd_byte;
    if (win_close) begin
      start_d  = any_q;
      commit_d = any_q & (~prot_on | unlk_q);
      any_d    = 1'b0;
      unlk_d   = 1'b0;
    end else if (ld_valid) begin
      any_d  = 1'b1;
      unlk_d = unlk_q | unlock;
    end
  end

  assign win_en = win_close | ld_valid;
  assign fwd_en = we_d;

  // Window state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q  <= 1'b0;
      unlk_q <= 1'b0;
    end else if (win_en) begin
      any_q  <= any_d;
      unlk_q <= unlk_d;
    end
  end

  // Pulse outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b0;
      start_q  <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      we_q     <= we_d;
      start_q  <= start_d;
      commit_q <= commit_d;
    end
  end

  // Forwarded byte, loaded only when a data byte passes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (fwd_en) begin
      addr_q <= ld_addr;
      data_q <= ld_data;
    end
  end

  assign buf_we      = we_q;
  assign buf_addr    = addr_q;
  assign buf_data    = data_q;
  assign prog_start  = start_q;
  assign prog_commit = commit_q;

endmodule

// File: rtl/sdp_guard.sv
module sdp_guard #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] A_ADDR    = 16'h5555,
  parameter logic [ADDR_W-1:0] B_ADDR    = 16'h2AAA,
  parameter logic [DATA_W-1:0] D_FIRST   = 8'hAA,
  parameter logic [DATA_W-1:0] D_SECOND  = 8'h55,
  parameter logic [DATA_W-1:0] D_ENABLE  = 8'hA0,
  parameter logic [DATA_W-1:0] D_DIS_MID = 8'h80,
  parameter logic [DATA_W-1:0] D_DISABLE = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              win_close,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_data,
  output logic              prog_start,
  output logic              prog_commit,
  output logic              prot_on
);

  logic cmd_byte, en_done, dis_done, unlock;

  sdp_seq_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .A_ADDR(A_ADDR), .B_ADDR(B_ADDR),
    .D_FIRST(D_FIRST), .D_SECOND(D_SECOND), .D_ENABLE(D_ENABLE),
    .D_DIS_MID(D_DIS_MID), .D_DISABLE(D_DISABLE)
  ) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .win_close(win_close),
    .cmd_byte (cmd_byte),
    .en_done  (en_done),
    .dis_done (dis_done)
  );

  sdp_prot_flag u_flag (
    .clk   (clk),
    .por_n (por_n),
    .set_i (en_done),
    .clr_i (dis_done),
    .prot_o(prot_on)
  );

  assign unlock = en_done | dis_done;

  sdp_window #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .ld_addr    (ld_addr),
    .ld_data    (ld_data),
    .win_close  (win_close),
    .cmd_byte   (cmd_byte),
    .unlock     (unlock),
    .prot_on    (prot_on),
    .buf_we     (buf_we),
    .buf_addr   (buf_addr),
    .buf_data   (buf_data),
    .prog_start (prog_start),
    .prog_commit(prog_commit)
  );

endmodule

// File: rtl/sdp_guard_chk.sv
module sdp_guard_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] A_ADDR    = 16'h5555,
  parameter logic [DATA_W-1:0] D_ENABLE  = 8'hA0,
  parameter logic [DATA_W-1:0] D_DISABLE = 8'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_n,
  input logic              ld_valid,
  input logic [ADDR_W-1:0] ld_addr,
  input logic [DATA_W-1:0] ld_data,
  input logic              win_close,
  input logic              buf_we,
  input logic              prog_start,
  input logic              prog_commit,
  input logic              prot_on
);

  // Input assumption: a load and a close never share a cycle
  assert_no_load_at_close_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !(ld_valid && win_close));

  assert_buf_we_follows_load_R1: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    buf_we |-> $past(ld_valid));

  assert_start_follows_close_R7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    prog_start |-> $past(win_close));

  assert_commit_with_start_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    prog_commit |-> prog_start);

  assert_reject_only_protected_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (prog_start && !prog_commit) |-> prot_on);

  assert_enable_by_command_R3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(prot_on) |-> ($past(ld_valid) && ($past(ld_addr) == A_ADDR)
                        && ($past(ld_data) == D_ENABLE)));

  assert_disable_by_command_R4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $fell(prot_on) |-> ($past(ld_valid) && ($past(ld_addr) == A_ADDR)
                        && ($past(ld_data) == D_DISABLE)));

  assert_command_not_buffered_R2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $changed(prot_on) |-> !buf_we);

endmodule

bind sdp_guard sdp_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .A_ADDR(A_ADDR), .D_ENABLE(D_ENABLE), .D_DISABLE(D_DISABLE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .por_n      (por_n),
  .ld_valid   (ld_valid),
  .ld_addr    (ld_addr),
  .ld_data    (ld_data),
  .win_close  (win_close),
  .buf_we     (buf_we),
  .prog_start (prog_start),
  .prog_commit(prog_commit),
  .prot_on    (prot_on)
);

// File: tb/sim_sdp_guard.sv
module sim_sdp_guard;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int NV = 41;

  // {op, addr, data, exp_we, exp_start, exp_commit, exp_prot}; op 0 = load, 1 = close
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 16'h0100, 8'h11, 4'b1000},   // 0  R1 plain data, unprotected
    {2'd1, 16'h0000, 8'h00, 4'b0110},   // 1  R7 R8 commit
    {2'd0, 16'h5555, 8'hAB, 4'b1000},   // 2  R5 mismatch at step 0
    {2'd0, 16'h2AAA, 8'h55, 4'b1000},   // 3  R6 no match after data
    {2'd1, 16'h0000, 8'h00, 4'b0110},   // 4
    {2'd1, 16'h0000, 8'h00, 4'b0000},   // 5  R7 empty window
    {2'd0, 16'h5555, 8'hAA, 4'b0000},   // 6  R2 consumed
    {2'd0, 16'h2AAA, 8'h55, 4'b0000},   // 7
    {2'd1, 16'h0000, 8'h00, 4'b0110},   // 8  partial prefix, unprotected
    {2'd0, 16'h5555, 8'hAA, 4'b0000},   // 9  R3 enable
    {2'd0, 16'h2AAA, 8'h55, 4'b0000},   // 10
    {2'd0, 16'h5555, 8'hA0, 4'b0001},   // 11
    {2'd0, 16'h0200, 8'h33, 4'b1001},   // 12 data after prefix
    {2'd1, 16'h0000, 8'h00, 4'b0111},   // 13
    {2'd0, 16'h0300, 8'h44, 4'b1001},   // 14 R8 no prefix
    {2'd1, 16'h0000, 8'h00, 4'b0101},   // 15 rejected
    {2'd0, 16'h5555, 8'hAA, 4'b0001},   // 16 unlock prefix
    {2'd0, 16'h2AAA, 8'h55, 4'b0001},   // 17
    {2'd0, 16'h5555, 8'hA0, 4'b0001},   // 18
    {2'd0, 16'h0400, 8'h55, 4'b1001},   // 19
    {2'd1, 16'h0000, 8'h00, 4'b0111},   // 20
    {2'd0, 16'h5555, 8'hAA, 4'b0001},   // 21 R5 consumed, then mismatch
    {2'd0, 16'h2AAA, 8'h99, 4'b1001},   // 22
    {2'd0, 16'h5555, 8'hA0, 4'b1001},   // 23 R6 locked
    {2'd1, 16'h0000, 8'h00, 4'b0101},   // 24 rejected
    {2'd0, 16'h5555, 8'hAA, 4'b0001},   // 25 R4 disable
    {2'd0, 16'h2AAA, 8'h55, 4'b0001},   // 26
    {2'd0, 16'h5555, 8'h80, 4'b0001},   // 27
    {2'd0, 16'h5555, 8'hAA, 4'b0001},   // 28
    {2'd0, 16'h2AAA, 8'h55, 4'b0001},   // 29
    {2'd0, 16'h5555, 8'h20, 4'b0000},   // 30
    {2'd1, 16'h0000, 8'h00, 4'b0110},   // 31
    {2'd0, 16'h0500, 8'h66, 4'b1000},   // 32
    {2'd1, 16'h0000, 8'h00, 4'b0110},   // 33
    {2'd0, 16'h5555, 8'hAA, 4'b0000},   // 34 disable while off
    {2'd0, 16'h2AAA, 8'h55, 4'b0000},   // 35
    {2'd0, 16'h5555, 8'h80, 4'b0000},   // 36
    {2'd0, 16'h5555, 8'hAA, 4'b0000},   // 37
    {2'd0, 16'h2AAA, 8'h55, 4'b0000},   // 38
    {2'd0, 16'h5555, 8'h20, 4'b0000},   // 39
    {2'd1, 16'h0000, 8'h00, 4'b0110}    // 40
  };

  logic          clk, rst_n, por_n, ld_valid, win_close;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;
  logic          buf_we, prog_start, prog_commit, prot_on;
  logic [AW-1:0] buf_addr;
  logic [DW-1:0] buf_data;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  sdp_guard u0 (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .win_close(win_close),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .prog_start(prog_start), .prog_commit(prog_commit), .prot_on(prot_on)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_close();
    @(negedge clk);
    win_close = 1'b1;
    @(negedge clk);
    win_close = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; por_n = 1'b0;
    ld_valid = 1'b0; win_close = 1'b0; ld_addr = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
    // Reset state: R9 R10
    chk("R10 prot_on after power-on", {31'd0, prot_on}, 32'd0);
    chk("R9 buf_we after reset", {31'd0, buf_we}, 32'd0);
    chk("R9 prog_start after reset", {31'd0, prog_start}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (VEC[i][29:28] == 2'd0) begin
        ld_valid = 1'b1; ld_addr = VEC[i][27:12]; ld_data = VEC[i][11:4];
      end else begin
        win_close = 1'b1;
      end
      @(negedge clk);
      ld_valid = 1'b0; win_close = 1'b0;
      if (VEC[i][29:28] == 2'd0) begin
        chk($sformatf("R1 R2 R5 R6 buf_we vec %0d", i), {31'd0, buf_we}, {31'd0, VEC[i][3]});
        if (VEC[i][3]) begin
          chk($sformatf("R1 buf_addr vec %0d", i), {16'd0, buf_addr}, {16'd0, VEC[i][27:12]});
          chk($sformatf("R1 buf_data vec %0d", i), {24'd0, buf_data}, {24'd0, VEC[i][11:4]});
        end
      end else begin
        chk($sformatf("R7 prog_start vec %0d", i), {31'd0, prog_start}, {31'd0, VEC[i][2]});
        chk($sformatf("R8 prog_commit vec %0d", i), {31'd0, prog_commit}, {31'd0, VEC[i][1]});
      end
      chk($sformatf("R3 R4 prot_on vec %0d", i), {31'd0, prot_on}, {31'd0, VEC[i][0]});
    end

    // R7: start pulse lasts one cycle
    do_load(16'h0600, 8'h77);
    @(negedge clk); win_close = 1'b1;
    @(negedge clk); win_close = 1'b0;
    chk("R7 start pulse", {31'd0, prog_start}, 32'd1);
    @(negedge clk);
    chk("R7 start one cycle", {31'd0, prog_start}, 32'd0);

    // R9: flag survives ordinary reset
    do_load(16'h5555, 8'hAA);
    do_load(16'h2AAA, 8'h55);
    do_load(16'h5555, 8'hA0);
    do_close();
    chk("R3 enabled before reset", {31'd0, prot_on}, 32'd1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R9 prot_on held in reset", {31'd0, prot_on}, 32'd1);
    chk("R9 prog_start cleared in reset", {31'd0, prog_start}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    do_load(16'h0700, 8'h88);
    chk("R9 data byte after reset", {31'd0, buf_we}, 32'd1);
    @(negedge clk); win_close = 1'b1;
    @(negedge clk); win_close = 1'b0;
    chk("R9 R8 start after reset", {31'd0, prog_start}, 32'd1);
    chk("R9 R8 rejected after reset", {31'd0, prog_commit}, 32'd0);

    // R9: reset drops a half-entered prefix
    do_load(16'h5555, 8'hAA);
    do_load(16'h2AAA, 8'h55);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_load(16'h5555, 8'hA0);
    chk("R9 prefix lost over reset", {31'd0, buf_we}, 32'd1);
    @(negedge clk); win_close = 1'b1;
    @(negedge clk); win_close = 1'b0;
    chk("R9 R8 rejected after prefix lost", {31'd0, prog_commit}, 32'd0);

    // R10: power-on initialization clears the flag
    @(negedge clk); por_n = 1'b0;
    @(negedge clk);
    chk("R10 por clears flag", {31'd0, prot_on}, 32'd0);
    @(negedge clk); por_n = 1'b1;
    do_load(16'h0800, 8'h99);
    @(negedge clk); win_close = 1'b1;
    @(negedge clk); win_close = 1'b0;
    chk("R10 R8 commit after por", {31'd0, prog_commit}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule